// File: doc/BRIEF.md
# Ready-Flagged Read-Only Serial Output Port

This block is the digital side of a read-only two-wire serial port for a converter. An upstream conversion path presents a 16-bit result, an out-of-range flag and a one-cycle update strobe. The block holds the result and pulls a single output line low to show that a word is waiting. The same line then carries the word out, one bit per falling edge of an externally supplied serial clock. The word is 24 bits long: the result first, then a status byte whose fixed fields let the reader confirm that the transfer was clean.

Each word can be read once. After the last bit the line goes back high and stays high until the next result is loaded. When a new strobe arrives, the line goes high at once and is held high for a parameterised number of system clocks before the new word replaces the old one. During that window the reader cannot start a read that would later be torn. The serial clock is sampled in the system clock domain through a synchronizer. An active-low power-down/reset input clears all state and turns the line driver off.

Top module: `rdy_serial_port`

## Requirements
- R1: While `pwr_rst_ni` is low, all state is cleared and `ser_oe_o` is 0, so the line is tristated.
- R2: After `pwr_rst_ni` rises, `ser_oe_o` is 1 from the next clock, and `ser_data_o` stays 1 until the first word is loaded. Serial clock edges before that have no effect on the line.
- R3: A word is loaded exactly LEAD_CYC clocks after the cycle in which `conv_valid_i` is high. From then on `ser_data_o` is 0, which means ready.
- R4: The word is `{conv_data_i, status}`, sent most significant bit first. Status bits 7..0 are: ready bit (0), constant 0, out-of-range, ID high (0), ID low (1), and check pattern 1, 0, 1. With no error the status byte is 8'b0000_1101.
- R5: Status bit 5 equals the `conv_ovr_i` value that was captured with the same strobe.
- R6: Each synchronized falling edge of `ser_clk_i` places the next word bit on `ser_data_o`. The synchronized rising edge that follows the 24th bit returns the line to 1.
- R7: After a complete read the line stays 1, and further serial clock edges are ignored until the next word is loaded.
- R8: The bit position is kept across any pause in the serial clock, so a read may be split into bursts.
- R9: From the clock after a strobe until the load, `ser_data_o` is 1 for LEAD_CYC cycles. An unread or partly read word is discarded, and the next read starts at the new word's MSB.
- R10: Serial clock edges that arrive during the withdrawal window are ignored. They do not advance the bit position of the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| pwr_rst_ni | input | 1 | Active-low power-down/reset, asynchronous assert |
| conv_valid_i | input | 1 | One-cycle strobe: a new conversion result is present |
| conv_data_i | input | DATA_W | Conversion result, offset binary |
| conv_ovr_i | input | 1 | Input was out of range during this conversion |
| ser_clk_i | input | 1 | Serial clock from the reader, idle high, asynchronous |
| ser_data_o | output | 1 | Combined ready flag / serial data value |
| ser_oe_o | output | 1 | Drive enable for the line; 0 means tristated |

## Verification
Single-bit checks follow the line through whole reads of fixed and random results, with the out-of-range flag both set and clear. A wrong bit order, a wrong status field or a lost error flag therefore shows up at a specific bit position. Reads are also split by long pauses and run at several serial clock speeds, which separates a design that keeps its bit position from one that loses it or depends on clock timing. Strobes that arrive over an unread word, over a partly read word, and while serial clock edges are arriving check the withdrawal window, the discarding of stale data, and the immunity to edges during the window. Resets in the middle of a read check the tristate and the clean restart.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

    localparam int STAT_W = 8;

    // identifier field and transfer-check field of the status byte
    localparam logic [1:0] DEV_ID    = 2'b01;
    localparam logic [2:0] CHECK_PAT = 3'b101;

    // status byte, bit 7 first: ready, zero, out-of-range, id[1:0], pattern[2:0]
    function automatic logic [STAT_W-1:0] status_byte(input logic ovr);
        return {1'b0, 1'b0, ovr, DEV_ID, CHECK_PAT};
    endfunction

endpackage

// File: rtl/rsp_edge_sync.sv
module rsp_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sclk_i,
    output logic fall_o,
    output logic rise_o
);

    // STAGES synchronizer flops plus one history flop for edge detection
    localparam int CW = STAGES + 1;

    typedef struct packed {
        logic [CW-1:0] chain;
    } sync_st_t;

    sync_st_t sync_d, sync_q;

    always_comb begin
        sync_d       = sync_q;
        sync_d.chain = {sync_q.chain[CW-2:0], sclk_i};
    end

    // idle level of the serial clock is high
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q <= '1;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign fall_o = sync_q.chain[CW-1] & ~sync_q.chain[CW-2];
    assign rise_o = ~sync_q.chain[CW-1] & sync_q.chain[CW-2];

endmodule

// File: rtl/rsp_update_seq.sv
module rsp_update_seq #(
    parameter int DATA_W   = 16,
    parameter int LEAD_CYC = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              strobe_i,
    input  logic [DATA_W-1:0] result_i,
    input  logic              ovr_i,
    output logic              withdraw_o,
    output logic              load_o,
    output logic [DATA_W-1:0] load_data_o,
    output logic              load_ovr_o
);

    localparam int                CNT_W   = (LEAD_CYC > 1) ? $clog2(LEAD_CYC) : 1;
    localparam logic [CNT_W-1:0]  CNT_TOP = CNT_W'(LEAD_CYC - 1);

    typedef struct packed {
        logic              pend;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] data;
        logic              ovr;
    } seq_st_t;

    seq_st_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (strobe_i) begin
            // new result: park it and start the lead count (restarts if pending)
            seq_d.pend = 1'b1;
            seq_d.cnt  = CNT_TOP;
            seq_d.data = result_i;
            seq_d.ovr  = ovr_i;
        end else if (seq_q.pend) begin
            if (seq_q.cnt == '0) begin
                seq_d.pend = 1'b0;
            end else begin
                seq_d.cnt = seq_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign withdraw_o  = strobe_i | seq_q.pend;
    assign load_o      = seq_q.pend & (seq_q.cnt == '0) & ~strobe_i;
    assign load_data_o = seq_q.data;
    assign load_ovr_o  = seq_q.ovr;

endmodule

// File: rtl/rsp_shift_out.sv
module rsp_shift_out
    import rsp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              fall_i,
    input  logic              rise_i,
    input  logic              withdraw_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              ovr_i,
    output logic              line_o
);

    localparam int               WORD_W = DATA_W + STAT_W;
    localparam int               BIT_W  = $clog2(WORD_W + 1);
    localparam logic [BIT_W-1:0] LAST   = BIT_W'(WORD_W);

    typedef struct packed {
        logic              valid;
        logic [BIT_W-1:0]  bits;
        logic [WORD_W-1:0] word;
        logic              line;
    } shf_st_t;

    shf_st_t shf_d, shf_q;

    always_comb begin
        shf_d = shf_q;
        if (load_i) begin
            // fresh word, shift state restarts, line signals ready
            shf_d.valid = 1'b1;
            shf_d.bits  = '0;
            shf_d.word  = {data_i, status_byte(ovr_i)};
            shf_d.line  = 1'b0;
        end else if (withdraw_i) begin
            // update pending: drop the old word and hold the line high
            shf_d.valid = 1'b0;
            shf_d.bits  = '0;
            shf_d.line  = 1'b1;
        end else if (shf_q.valid) begin
            if (fall_i && (shf_q.bits != LAST)) begin
                shf_d.line = shf_q.word[WORD_W-1];
                shf_d.word = {shf_q.word[WORD_W-2:0], 1'b0};
                shf_d.bits = shf_q.bits + BIT_W'(1);
            end else if (rise_i && (shf_q.bits == LAST)) begin
                // last bit ended: word consumed
                shf_d.valid = 1'b0;
                shf_d.bits  = '0;
                shf_d.line  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            shf_q <= '{valid: 1'b0, bits: '0, word: '0, line: 1'b1};
        end else begin
            shf_q <= shf_d;
        end
    end

    assign line_o = shf_q.line;

endmodule

// File: rtl/rdy_serial_port.sv
module rdy_serial_port #(
    parameter int DATA_W      = 16,
    parameter int LEAD_CYC    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              pwr_rst_ni,
    input  logic              conv_valid_i,
    input  logic [DATA_W-1:0] conv_data_i,
    input  logic              conv_ovr_i,
    input  logic              ser_clk_i,
    output logic              ser_data_o,
    output logic              ser_oe_o
);

    logic              sclk_fall;
    logic              sclk_rise;
    logic              withdraw;
    logic              load;
    logic [DATA_W-1:0] load_data;
    logic              load_ovr;

    typedef struct packed {
        logic oe;
    } top_st_t;

    top_st_t top_d, top_q;

    rsp_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (pwr_rst_ni),
        .sclk_i (ser_clk_i),
        .fall_o (sclk_fall),
        .rise_o (sclk_rise)
    );

    rsp_update_seq #(
        .DATA_W   (DATA_W),
        .LEAD_CYC (LEAD_CYC)
    ) u_seq (
        .clk_i       (clk_i),
        .rst_ni      (pwr_rst_ni),
        .strobe_i    (conv_valid_i),
        .result_i    (conv_data_i),
        .ovr_i       (conv_ovr_i),
        .withdraw_o  (withdraw),
        .load_o      (load),
        .load_data_o (load_data),
        .load_ovr_o  (load_ovr)
    );

    rsp_shift_out #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk_i      (clk_i),
        .rst_ni     (pwr_rst_ni),
        .fall_i     (sclk_fall),
        .rise_i     (sclk_rise),
        .withdraw_i (withdraw),
        .load_i     (load),
        .data_i     (load_data),
        .ovr_i      (load_ovr),
        .line_o     (ser_data_o)
    );

    // driver enable: off in power-down, on from the first clock after release
    always_comb begin
        top_d    = top_q;
        top_d.oe = 1'b1;
    end

    always_ff @(posedge clk_i or negedge pwr_rst_ni) begin
        if (!pwr_rst_ni) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign ser_oe_o = top_q.oe;

endmodule

// File: rtl/rdy_serial_port_chk.sv
module rdy_serial_port_chk #(
    parameter int LEAD_CYC = 4
) (
    input logic clk_i,
    input logic pwr_rst_ni,
    input logic conv_valid_i,
    input logic ser_data_o,
    input logic ser_oe_o
);

    localparam int SW = $clog2(LEAD_CYC + 3) + 1;

    logic          rst_low_q;
    logic          seen_q;
    logic [SW-1:0] since_q;

    always_ff @(posedge clk_i) begin
        rst_low_q <= ~pwr_rst_ni;
    end

    always_ff @(posedge clk_i or negedge pwr_rst_ni) begin
        if (!pwr_rst_ni) begin
            seen_q  <= 1'b0;
            since_q <= '0;
        end else begin
            if (conv_valid_i) begin
                seen_q  <= 1'b1;
                since_q <= SW'(1);
            end else if ((since_q != '0) && (since_q <= SW'(LEAD_CYC + 1))) begin
                since_q <= since_q + SW'(1);
            end
        end
    end

    always @(negedge clk_i) begin
        if (!pwr_rst_ni && rst_low_q) begin
            AST_OE_OFF_IN_RESET: assert (!ser_oe_o) else $error("driver on during power-down"); // R1
        end
    end

    AST_OE_ON_AFTER_RESET: assert property (@(posedge clk_i) disable iff (!pwr_rst_ni)
        $past(pwr_rst_ni) |-> ser_oe_o) else $error("driver off after release"); // R2

    AST_HIGH_BEFORE_DATA: assert property (@(posedge clk_i) disable iff (!pwr_rst_ni)
        !seen_q |-> ser_data_o) else $error("line low before any word"); // R2

    AST_WITHDRAW_WINDOW: assert property (@(posedge clk_i) disable iff (!pwr_rst_ni)
        ((since_q != '0) && (since_q <= SW'(LEAD_CYC))) |-> ser_data_o)
        else $error("line low inside withdrawal window"); // R9

    AST_READY_AT_LOAD: assert property (@(posedge clk_i) disable iff (!pwr_rst_ni)
        (since_q == SW'(LEAD_CYC + 1)) |-> !ser_data_o)
        else $error("line not ready after load"); // R3

endmodule

bind rdy_serial_port rdy_serial_port_chk #(
    .LEAD_CYC (LEAD_CYC)
) u_chk (
    .clk_i        (clk_i),
    .pwr_rst_ni   (pwr_rst_ni),
    .conv_valid_i (conv_valid_i),
    .ser_data_o   (ser_data_o),
    .ser_oe_o     (ser_oe_o)
);

// File: tb/rdy_serial_port_tb.sv
module rdy_serial_port_tb;

    localparam int CLK_PERIOD = 10;
    localparam int TB_LEAD    = 20;

    logic        clk = 1'b0;
    logic        pwr_rst_ni = 1'b0;
    logic        conv_valid = 1'b0;
    logic [15:0] conv_data = '0;
    logic        conv_ovr = 1'b0;
    logic        sclk = 1'b1;
    logic        sdo;
    logic        oe;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rdy_serial_port #(
        .DATA_W   (16),
        .LEAD_CYC (TB_LEAD)
    ) u_dut (
        .clk_i        (clk),
        .pwr_rst_ni   (pwr_rst_ni),
        .conv_valid_i (conv_valid),
        .conv_data_i  (conv_data),
        .conv_ovr_i   (conv_ovr),
        .ser_clk_i    (sclk),
        .ser_data_o   (sdo),
        .ser_oe_o     (oe)
    );

    // expected word: result then {0, 0, ovr, 0, 1, 1, 0, 1}
    function automatic logic [23:0] exp_word(input logic [15:0] d, input logic ovr);
        return {d, 2'b00, ovr, 2'b01, 3'b101};
    endfunction

    task automatic check(input logic act, input logic exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    // strobe a result and follow the withdrawal window up to the load
    task automatic strobe(input logic [15:0] d, input logic ovr);
        @(negedge clk);
        conv_valid = 1'b1;
        conv_data  = d;
        conv_ovr   = ovr;
        @(negedge clk);
        conv_valid = 1'b0;
        check(sdo, 1'b1, "R9 withdrawn after strobe");
        for (int k = 1; k < TB_LEAD; k++) begin
            @(negedge clk);
            check(sdo, 1'b1, "R9 window");
        end
        @(negedge clk);
        check(sdo, 1'b0, "R3 ready after load");
    endtask

    task automatic read_bits(input logic [23:0] w, input int first, input int n,
                             input int half, input string tag);
        for (int i = first; i < first + n; i++) begin
            sclk = 1'b0;
            wait_neg(half);
            check(sdo, w[23 - i], tag);
            sclk = 1'b1;
            wait_neg(half);
        end
    endtask

    task automatic idle_pulses(input int n, input logic exp, input string tag);
        for (int i = 0; i < n; i++) begin
            sclk = 1'b0;
            wait_neg(4);
            check(sdo, exp, tag);
            sclk = 1'b1;
            wait_neg(4);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [23:0] w;
        logic [15:0] d;
        logic        e;
        int          half;
        void'($urandom(32'd4711));

        // reset state
        wait_neg(5);
        check(oe, 1'b0, "R1 tristate in reset");
        pwr_rst_ni = 1'b1;
        wait_neg(3);
        check(oe, 1'b1, "R2 driven after release");
        check(sdo, 1'b1, "R2 high before first word");
        idle_pulses(3, 1'b1, "R2 edges ignored before first word");

        // directed full read
        w = exp_word(16'hA5C3, 1'b0);
        strobe(16'hA5C3, 1'b0);
        read_bits(w, 0, 24, 4, "R4 word order");
        check(sdo, 1'b1, "R6 high after last rise");
        idle_pulses(3, 1'b1, "R7 single read");

        // out-of-range flag
        w = exp_word(16'h0F0F, 1'b1);
        strobe(16'h0F0F, 1'b1);
        read_bits(w, 0, 18, 3, "R4 data part");
        read_bits(w, 18, 1, 3, "R5 error bit");
        read_bits(w, 19, 5, 3, "R4 status tail");
        check(sdo, 1'b1, "R6 end of word");

        // burst read with long pause
        w = exp_word(16'h3C96, 1'b0);
        strobe(16'h3C96, 1'b0);
        read_bits(w, 0, 10, 5, "R8 first burst");
        wait_neg(60);
        check(sdo, w[14], "R8 held during pause");
        read_bits(w, 10, 14, 5, "R8 second burst");
        check(sdo, 1'b1, "R6 end after bursts");

        // unread word replaced
        strobe(16'h1234, 1'b0);
        wait_neg(30);
        w = exp_word(16'h8765, 1'b1);
        strobe(16'h8765, 1'b1);
        read_bits(w, 0, 24, 4, "R9 unread replaced");

        // partly read word replaced
        strobe(16'hFFFF, 1'b0);
        read_bits(exp_word(16'hFFFF, 1'b0), 0, 7, 4, "R4 partial");
        w = exp_word(16'h0001, 1'b0);
        strobe(16'h0001, 1'b0);
        read_bits(w, 0, 24, 4, "R9 restart at MSB");

        // serial clock edges inside the withdrawal window
        w = exp_word(16'hC0DE, 1'b0);
        @(negedge clk);
        conv_valid = 1'b1;
        conv_data  = 16'hC0DE;
        conv_ovr   = 1'b0;
        @(negedge clk);
        conv_valid = 1'b0;
        sclk = 1'b0;
        wait_neg(3);
        check(sdo, 1'b1, "R10 window holds high");
        sclk = 1'b1;
        wait_neg(3);
        sclk = 1'b0;
        wait_neg(3);
        sclk = 1'b1;
        wait_neg(14);
        check(sdo, 1'b0, "R10 ready, position not advanced");
        read_bits(w, 0, 24, 4, "R10 full word after window");

        // random results, speeds and pauses
        for (int it = 0; it < 24; it++) begin
            d    = 16'($urandom);
            e    = 1'($urandom);
            half = 3 + int'($urandom % 5);
            w    = exp_word(d, e);
            strobe(d, e);
            if ((it % 3) == 0) begin
                read_bits(w, 0, 12, half, "R8 random burst");
                wait_neg(10 + int'($urandom % 40));
                read_bits(w, 12, 12, half, "R8 random burst");
            end else begin
                read_bits(w, 0, 24, half, "R4 random word");
            end
            check(sdo, 1'b1, "R7 random read done");
        end

        // power-down in the middle of a read
        strobe(16'h5A5A, 1'b1);
        read_bits(exp_word(16'h5A5A, 1'b1), 0, 5, 4, "R4 before power-down");
        pwr_rst_ni = 1'b0;
        wait_neg(3);
        check(oe, 1'b0, "R1 tristate mid-read");
        pwr_rst_ni = 1'b1;
        wait_neg(3);
        check(oe, 1'b1, "R2 driven again");
        check(sdo, 1'b1, "R2 high after power-down");
        idle_pulses(2, 1'b1, "R2 old word gone");

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule